// File: doc/BRIEF.md
# Load-Store Memory Hazard Checker

This block works beside a reorder buffer in an out-of-order core. It decides whether a pending load may start its memory access. It keeps a small circular queue of stores that have been allocated but not yet committed. Each entry holds the store's reorder-buffer tag, its word address, and a flag that shows whether that address has been computed yet. Every cycle the presented load is compared against all in-flight stores that are older than it. The load gets a go signal only when none of those stores could write the location it reads.

Stores leave the queue only through commit. Commit always takes the oldest entry and presents its address and tag as a memory write, so memory is updated in program order. A flush empties the queue and drops any load presented in that cycle. Age is measured as the distance of a tag from the current reorder-buffer head, modulo the buffer size, so the comparison stays correct when tags wrap.

Top module: `ldst_hazard_gate`

## Requirements
- R1: After reset the queue is empty and `sqFull` is 0. A presented load gets `loadGo`=1 and `loadStall`=0.
- R2: A load stalls (`loadStall`=1, `loadGo`=0) when an in-flight store older than it has a known address equal to `loadAddr`.
- R3: A load stalls when an in-flight store older than it has not yet received its address.
- R4: A load goes when every older in-flight store has a known address that differs from `loadAddr`.
- R5: Stores younger than the load never cause a stall. Store A is older than load B when (tagA − robHead) mod 16 < (tagB − robHead) mod 16, with 4-bit tags.
- R6: With `commitValid`=1 and a non-empty queue, the oldest entry is released in the same cycle: `memWrValid`=1, with `memWrAddr` and `memWrTag` taken from that entry. Entries are released in allocation order, and a released store no longer blocks loads.
- R7: In a cycle where `flush`=1, both `loadGo` and `loadStall` are 0. From the next cycle on, the queue is empty.
- R8: The queue holds 8 stores. `sqFull` is 1 when 8 are in flight, and an allocation while full is ignored.
- R9: `loadGo` and `loadStall` are never 1 together, and both are 0 when `loadValid`=0.
- R10: A commit request on an empty queue gives `memWrValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| robHead | input | 4 | Tag of the oldest reorder-buffer entry, used as the age origin |
| allocValid | input | 1 | Allocate a new store entry |
| allocTag | input | 4 | Reorder-buffer tag of the new store |
| addrValid | input | 1 | A store's address has been computed |
| addrTag | input | 4 | Tag of the store whose address arrives |
| addrValue | input | 32 | Store word address |
| loadValid | input | 1 | A load requests its memory access |
| loadTag | input | 4 | Reorder-buffer tag of the load |
| loadAddr | input | 32 | Load word address |
| commitValid | input | 1 | The oldest store commits this cycle |
| flush | input | 1 | Discard all in-flight stores and any pending load |
| loadGo | output | 1 | The load may access memory |
| loadStall | output | 1 | The load must wait |
| sqFull | output | 1 | All store entries are occupied |
| memWrValid | output | 1 | A committed store is released to memory |
| memWrAddr | output | 32 | Address of the released store |
| memWrTag | output | 4 | Tag of the released store |

## Verification
The assertions assume that tags of in-flight stores are unique and that the load's tag is not one of them. They also assume that an address update names a store that is already in flight, and that no store commits before its address is known. The stimulus meets these conditions: it uses distinct tags for every store and load in a phase, sends each address only after the store has been allocated, and supplies every address before that store is committed. The probe table moves `robHead` so that the same stored tags count as older in one row and younger in another, which exercises the wrap-around of the age rule.

// File: rtl/ldst_hazard_pkg.sv
package ldst_hazard_pkg;
  localparam int StoreSlots = 8;
  localparam int RobTagW    = 4;
  localparam int WordAddrW  = 32;
  localparam int SlotIdxW   = $clog2(StoreSlots);

  // strobes from control to datapath
  typedef struct packed {
    logic                allocEn;
    logic [SlotIdxW-1:0] allocIdx;
    logic                commitEn;
    logic [SlotIdxW-1:0] commitIdx;
    logic                clearAll;
  } slotStrobes_t;

  // true when tag a is older than tag b, measured from head (modulo tag space)
  function automatic logic isOlder(input logic [RobTagW-1:0] a,
                                   input logic [RobTagW-1:0] b,
                                   input logic [RobTagW-1:0] head);
    logic [RobTagW-1:0] distA;
    logic [RobTagW-1:0] distB;
    distA = a - head;
    distB = b - head;
    return distA < distB;
  endfunction
endpackage

// File: rtl/ldst_hazard_ctrl.sv
module ldst_hazard_ctrl
  import ldst_hazard_pkg::*;
#(
  parameter int NumSlots = StoreSlots
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         allocValid,
  input  logic         commitValid,
  input  logic         flush,
  output slotStrobes_t strb,
  output logic         full
);
  localparam int IdxW = $clog2(NumSlots);
  localparam int CntW = IdxW + 1;

  logic [IdxW-1:0] headPtr;
  logic [IdxW-1:0] tailPtr;
  logic [CntW-1:0] fillCount;
  logic            emptyQ;
  logic            allocOk;
  logic            commitOk;

  assign full     = (fillCount == CntW'(NumSlots));
  assign emptyQ   = (fillCount == '0);
  assign allocOk  = allocValid && !full && !flush;
  assign commitOk = commitValid && !emptyQ && !flush;

  always_comb begin
    strb.allocEn   = allocOk;
    strb.allocIdx  = tailPtr;
    strb.commitEn  = commitOk;
    strb.commitIdx = headPtr;
    strb.clearAll  = flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      fillCount <= '0;
    end else if (flush) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      fillCount <= '0;
    end else begin
      if (allocOk)  tailPtr <= tailPtr + 1'b1;
      if (commitOk) headPtr <= headPtr + 1'b1;
      case ({allocOk, commitOk})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end
endmodule

// File: rtl/ldst_hazard_dpath.sv
module ldst_hazard_dpath
  import ldst_hazard_pkg::*;
#(
  parameter int NumSlots = StoreSlots,
  parameter int TagW     = RobTagW,
  parameter int AddrW    = WordAddrW
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotStrobes_t     strb,
  input  logic [TagW-1:0]  allocTag,
  input  logic             addrValid,
  input  logic [TagW-1:0]  addrTag,
  input  logic [AddrW-1:0] addrValue,
  input  logic [TagW-1:0]  robHead,
  input  logic [TagW-1:0]  loadTag,
  input  logic [AddrW-1:0] loadAddr,
  output logic             hazard,
  output logic [AddrW-1:0] headAddr,
  output logic [TagW-1:0]  headTag
);
  logic             slotValid [NumSlots];
  logic             slotKnown [NumSlots];
  logic [TagW-1:0]  slotTag   [NumSlots];
  logic [AddrW-1:0] slotAddr  [NumSlots];
  logic [NumSlots-1:0] blockVec;

  for (genvar i = 0; i < NumSlots; i++) begin : g_slot
    logic allocHere;
    logic commitHere;
    logic addrHere;
    logic olderThanLoad;
    logic addrMatch;

    assign allocHere  = strb.allocEn  && (strb.allocIdx  == i[SlotIdxW-1:0]);
    assign commitHere = strb.commitEn && (strb.commitIdx == i[SlotIdxW-1:0]);
    assign addrHere   = addrValid && slotValid[i] && (slotTag[i] == addrTag) && !allocHere;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[i] <= 1'b0;
        slotKnown[i] <= 1'b0;
        slotTag[i]   <= '0;
        slotAddr[i]  <= '0;
      end else if (strb.clearAll) begin
        slotValid[i] <= 1'b0;
        slotKnown[i] <= 1'b0;
      end else begin
        if (commitHere) slotValid[i] <= 1'b0;
        if (allocHere) begin
          slotValid[i] <= 1'b1;
          slotKnown[i] <= 1'b0;
          slotTag[i]   <= allocTag;
        end
        if (addrHere) begin
          slotKnown[i] <= 1'b1;
          slotAddr[i]  <= addrValue;
        end
      end
    end

    // an older store blocks if its address is unknown or equal to the load's
    assign olderThanLoad = slotValid[i] && isOlder(slotTag[i], loadTag, robHead);
    assign addrMatch     = slotKnown[i] && (slotAddr[i] == loadAddr);
    assign blockVec[i]   = olderThanLoad && (!slotKnown[i] || addrMatch);
  end

  assign hazard   = |blockVec;
  assign headAddr = slotAddr[strb.commitIdx];
  assign headTag  = slotTag[strb.commitIdx];
endmodule

// File: rtl/ldst_hazard_gate.sv
module ldst_hazard_gate
  import ldst_hazard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [RobTagW-1:0]   robHead,
  input  logic                 allocValid,
  input  logic [RobTagW-1:0]   allocTag,
  input  logic                 addrValid,
  input  logic [RobTagW-1:0]   addrTag,
  input  logic [WordAddrW-1:0] addrValue,
  input  logic                 loadValid,
  input  logic [RobTagW-1:0]   loadTag,
  input  logic [WordAddrW-1:0] loadAddr,
  input  logic                 commitValid,
  input  logic                 flush,
  output logic                 loadGo,
  output logic                 loadStall,
  output logic                 sqFull,
  output logic                 memWrValid,
  output logic [WordAddrW-1:0] memWrAddr,
  output logic [RobTagW-1:0]   memWrTag
);
  slotStrobes_t strb;
  logic         hazard;

  ldst_hazard_ctrl #(.NumSlots(StoreSlots)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .commitValid(commitValid),
    .flush(flush), .strb(strb), .full(sqFull)
  );

  ldst_hazard_dpath #(.NumSlots(StoreSlots), .TagW(RobTagW), .AddrW(WordAddrW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .allocTag(allocTag),
    .addrValid(addrValid), .addrTag(addrTag), .addrValue(addrValue),
    .robHead(robHead), .loadTag(loadTag), .loadAddr(loadAddr),
    .hazard(hazard), .headAddr(memWrAddr), .headTag(memWrTag)
  );

  assign loadGo     = loadValid && !flush && !hazard;
  assign loadStall  = loadValid && !flush && hazard;
  assign memWrValid = strb.commitEn;
endmodule

// File: rtl/ldst_hazard_gate_chk.sv
module ldst_hazard_gate_chk (
  input logic clk,
  input logic rstN,
  input logic loadValid,
  input logic commitValid,
  input logic flush,
  input logic loadGo,
  input logic loadStall,
  input logic sqFull,
  input logic memWrValid
);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadGo, loadStall}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> !loadGo && !loadStall);

  assert_flush_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !loadGo && !loadStall);

  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !sqFull && !loadStall);

  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    sqFull && !commitValid && !flush |=> sqFull);

  assert_write_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> commitValid && !flush);

  assert_empty_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) && rstN && $past(rstN) |-> !memWrValid);
endmodule

bind ldst_hazard_gate ldst_hazard_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .loadValid(loadValid), .commitValid(commitValid),
  .flush(flush), .loadGo(loadGo), .loadStall(loadStall), .sqFull(sqFull),
  .memWrValid(memWrValid)
);

// File: tb/ldst_hazard_gate_test.sv
module ldst_hazard_gate_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  robHead = '0;
  logic        allocValid = 1'b0;
  logic [3:0]  allocTag = '0;
  logic        addrValid = 1'b0;
  logic [3:0]  addrTag = '0;
  logic [31:0] addrValue = '0;
  logic        loadValid = 1'b0;
  logic [3:0]  loadTag = '0;
  logic [31:0] loadAddr = '0;
  logic        commitValid = 1'b0;
  logic        flush = 1'b0;
  logic        loadGo, loadStall, sqFull, memWrValid;
  logic [31:0] memWrAddr;
  logic [3:0]  memWrTag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ldst_hazard_gate uut (.*);

  // {robHead, loadTag, loadAddr, expectGo}; stores in flight: tag2@0x100, tag6@0x200, tag9 unknown
  localparam logic [40:0] ProbeTab [11] = '{
    {4'd0,  4'd1,  32'h100, 1'b1},  // R5 all stores younger
    {4'd0,  4'd3,  32'h100, 1'b0},  // R2 tag2 matches
    {4'd0,  4'd3,  32'h104, 1'b1},  // R4 differs
    {4'd0,  4'd7,  32'h200, 1'b0},  // R2 tag6 matches
    {4'd0,  4'd7,  32'h300, 1'b1},  // R4
    {4'd0,  4'd10, 32'h300, 1'b0},  // R3 tag9 unknown and older
    {4'd8,  4'd10, 32'h100, 1'b0},  // R3 wrap: tag9 older than tag10
    {4'd8,  4'd8,  32'h300, 1'b1},  // R5 wrap: load oldest
    {4'd4,  4'd7,  32'h200, 1'b0},  // R2 with head 4
    {4'd4,  4'd3,  32'h400, 1'b0},  // R3 wrap: tag9 older than tag3
    {4'd4,  4'd5,  32'h100, 1'b1}   // R5 tag2 younger under head 4
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic allocStore(input logic [3:0] t);
    @(negedge clk); allocValid = 1'b1; allocTag = t;
    @(negedge clk); allocValid = 1'b0;
  endtask

  task automatic giveAddr(input logic [3:0] t, input logic [31:0] a);
    @(negedge clk); addrValid = 1'b1; addrTag = t; addrValue = a;
    @(negedge clk); addrValid = 1'b0;
  endtask

  task automatic probe(input logic [3:0] h, input logic [3:0] t, input logic [31:0] a,
                       input bit expGo, input string req);
    @(negedge clk); robHead = h; loadValid = 1'b1; loadTag = t; loadAddr = a;
    #1;
    check(loadGo == expGo && loadStall == !expGo, req, {30'd0, loadGo, loadStall}, {30'd0, expGo, !expGo});
    loadValid = 1'b0;
  endtask

  task automatic commitOne(input bit expValid, input logic [3:0] expTag,
                           input logic [31:0] expAddr, input string req);
    @(negedge clk); commitValid = 1'b1;
    #1;
    check(memWrValid == expValid, req, {31'd0, memWrValid}, {31'd0, expValid});
    if (expValid) begin
      check(memWrTag == expTag, req, {28'd0, memWrTag}, {28'd0, expTag});
      check(memWrAddr == expAddr, req, memWrAddr, expAddr);
    end
    @(negedge clk); commitValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    check(sqFull == 1'b0, "R1 full", {31'd0, sqFull}, 32'd0);
    probe(4'd0, 4'd3, 32'h100, 1'b1, "R1 load after reset");
    // R9 idle load
    #1; check(!loadGo && !loadStall, "R9 idle", {30'd0, loadGo, loadStall}, 32'd0);
    // R10 empty commit
    commitOne(1'b0, 4'd0, 32'd0, "R10 empty commit");

    allocStore(4'd2); allocStore(4'd6); allocStore(4'd9);
    giveAddr(4'd2, 32'h100); giveAddr(4'd6, 32'h200);
    for (int k = 0; k < 11; k++) begin
      probe(ProbeTab[k][40:37], ProbeTab[k][36:33], ProbeTab[k][32:1], ProbeTab[k][0],
            $sformatf("R2-R5 probe %0d", k));
    end

    // R6 commit oldest, then it no longer blocks
    commitOne(1'b1, 4'd2, 32'h100, "R6 commit head");
    probe(4'd0, 4'd3, 32'h100, 1'b1, "R6 released store no longer blocks");

    // R7 flush drops load this cycle, queue empty after
    @(negedge clk); flush = 1'b1; robHead = 4'd0; loadValid = 1'b1; loadTag = 4'd10; loadAddr = 32'h300;
    #1; check(!loadGo && !loadStall, "R7 flush drop", {30'd0, loadGo, loadStall}, 32'd0);
    @(negedge clk); flush = 1'b0;
    #1; check(loadGo && !loadStall, "R7 after flush", {30'd0, loadGo, loadStall}, 32'd2);
    loadValid = 1'b0;

    // R8 capacity and ignored allocation, R6 order
    for (int t = 0; t < 8; t++) begin
      allocStore(4'(t));
      giveAddr(4'(t), 32'h1000 + 32'(t) * 4);
    end
    #1; check(sqFull == 1'b1, "R8 full at 8", {31'd0, sqFull}, 32'd1);
    allocStore(4'd8);
    probe(4'd0, 4'd8, 32'h1008, 1'b0, "R2 full queue match");
    for (int t = 0; t < 8; t++) begin
      commitOne(1'b1, 4'(t), 32'h1000 + 32'(t) * 4, "R6 order");
    end
    commitOne(1'b0, 4'd0, 32'd0, "R8 alloc while full ignored");
    #1; check(sqFull == 1'b0, "R8 not full", {31'd0, sqFull}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule